// File: doc/BRIEF.md
# Reloadable Interval and Edge-Capture Timer

This block combines three timing functions that share one prescaled time base. A prescaler takes one of two one-cycle enable strobes, picked by a select input, and divides it by 2, 4, 6 or 8. Each prescaled tick steps a 12-bit interval counter that counts down. When it is at zero, the tick reloads it from a reload input and raises a one-cycle pulse. That pulse serves as the interval interrupt, and it can also be gated out to a timer output pin. The same tick advances a 16-bit free-running counter, which flags a one-cycle wrap interrupt each time it rolls over.

Two capture pins are synchronised and edge-detected. Each edge direction on each pin is its own capture event, with its own 16-bit data register and status bit. A single hold-policy input picks the behaviour for all events. In one setting, every edge overwrites the stored time. In the other, the first edge since the status was cleared is kept. Status bits are cleared by writing ones through a mask strobe.

Top module: `ivl_cap_timer`

## Requirements
- R1: While reset is asserted, every counter, capture register, status bit, interrupt and the timer pin output read zero.
- R2: The prescaler follows `src_a` when `src_sel` is 0 and `src_b` when it is 1. It emits one tick for every 2*(`ratio_sel`+1) selected strobes. Because it fires whenever its internal count is at or above the terminal value, a ratio change during a count cannot stall it.
- R3: On each tick the interval count drops by one. A tick that finds it at zero loads `reload_val` instead, and `ivl_irq` is high for exactly the next cycle. With a steady reload value N, the period is N+1 ticks.
- R4: `reload_val` is sampled only when a reload happens. Changing it in the middle of a count leaves the running count untouched.
- R5: `tio_out` copies `ivl_irq` while `tio_en` is 1 and stays low while `tio_en` is 0.
- R6: The free-running counter increments by one on each tick and rolls over from 0xFFFF to 0. `wrap_irq` is high for the one cycle after the rollover.
- R7: Event index 2*i is a rising edge on `cap_in[i]`, and index 2*i+1 is a falling edge. Its data is `cap_data[16*k +: 16]` and its status is `cap_status[k]`. Suppose a pin level first appears at clock edge e. The event then fires at edge e+2 and stores the free-running count as it was just before that edge.
- R8: With `first_hold` at 0, every event overwrites its data register.
- R9: With `first_hold` at 1, an event whose status is already set leaves its data unchanged.
- R10: A cycle with `clr_we` high clears each status bit whose `clr_mask` bit is 1. Bits with a 0 mask are unaffected.
- R11: If an event and a clear of the same status occur in one cycle, the status stays set and the data takes the new value, even under `first_hold`.
- R12: One pin transition yields exactly one event. A pin held at a steady level causes no further capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a | input | 1 | Time-base strobe, choice 0 |
| src_b | input | 1 | Time-base strobe, choice 1 |
| src_sel | input | 1 | Selects the strobe fed to the prescaler |
| ratio_sel | input | 2 | Prescale ratio 2*(value+1) |
| reload_val | input | 12 | Interval reload value |
| tio_en | input | 1 | Routes the interval pulse to `tio_out` |
| first_hold | input | 1 | 1 keeps the first capture, 0 keeps the latest |
| cap_in | input | 2 | Capture pins |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Status bits to clear, one per event |
| ivl_count | output | 12 | Interval counter value |
| ivl_irq | output | 1 | One-cycle interval reload pulse |
| tio_out | output | 1 | Gated interval pulse for the timer pin |
| frc_count | output | 16 | Free-running counter value |
| wrap_irq | output | 1 | One-cycle rollover pulse |
| cap_status | output | 4 | Capture status per event |
| cap_data | output | 64 | Captured counts, 16 bits per event |

## Verification
The bench changes the reload value partway through a count. A design that loads it at once would shorten the current period and shift every later pulse. Clears are swept across the cycle where an event lands, so a design that lets the clear win would drop the status, and one that obeys the hold policy there would keep a stale stamp. All four ratios are run with a gappy strobe to catch an off-by-one divider. The counter is run through a real rollover to catch a missing or mistimed wrap pulse. Capture latency is also checked against the stamp value, where an extra or missing synchroniser stage would store a count that is off by one tick.

// File: rtl/ict_pkg.sv
package ict_pkg;
  localparam int RSEL_W = 2;
  localparam int PCNT_W = RSEL_W + 1;

  // last prescaler count before a tick: ratio 2*(sel+1) means terminal 2*sel+1
  function automatic logic [PCNT_W-1:0] presc_last(input logic [RSEL_W-1:0] sel);
    return {sel, 1'b1};
  endfunction

  // whether an event may overwrite its stored stamp
  function automatic logic cap_take(input logic hold, input logic held, input logic clr);
    return !hold || !held || clr;
  endfunction
endpackage

// File: rtl/ict_prescaler.sv
module ict_prescaler
  import ict_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_a,
  input  logic              src_b,
  input  logic              src_sel,
  input  logic [RSEL_W-1:0] ratio_sel,
  output logic              tick
);
  logic              src;
  logic [PCNT_W-1:0] pcnt;

  assign src  = src_sel ? src_b : src_a;
  assign tick = src && (pcnt >= presc_last(ratio_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else if (src) pcnt <= tick ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/ict_interval.sv
module ict_interval #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         pulse
);
  logic at_term;
  assign at_term = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= tick && at_term;
      if (tick) count <= at_term ? reload : count - 1'b1;
    end
  end
endmodule

// File: rtl/ict_frc.sv
module ict_frc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      wrap <= tick && (&count);
      if (tick) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ict_capture_ch.sv
module ict_capture_ch
  import ict_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pin,
  input  logic           hold,
  input  logic [W-1:0]   stamp,
  input  logic [1:0]     clr,
  output logic [1:0]     evt,
  output logic [1:0]     held,
  output logic [2*W-1:0] data
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= pin;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign evt[0] = s2 & ~prev;
  assign evt[1] = ~s2 & prev;

  for (genvar e = 0; e < 2; e++) begin : g_slot
    logic         st_q;
    logic [W-1:0] dat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= 1'b0;
        dat_q <= '0;
      end else if (evt[e]) begin
        if (cap_take(hold, st_q, clr[e])) dat_q <= stamp;
        st_q <= 1'b1;
      end else if (clr[e]) begin
        st_q <= 1'b0;
      end
    end
    assign held[e]          = st_q;
    assign data[e*W +: W]   = dat_q;
  end
endmodule

// File: rtl/ivl_cap_timer.sv
module ivl_cap_timer
  import ict_pkg::*;
#(
  parameter int IVL_W = 12,
  parameter int FRC_W = 16,
  parameter int NCAP  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    src_a,
  input  logic                    src_b,
  input  logic                    src_sel,
  input  logic [RSEL_W-1:0]       ratio_sel,
  input  logic [IVL_W-1:0]        reload_val,
  input  logic                    tio_en,
  input  logic                    first_hold,
  input  logic [NCAP-1:0]         cap_in,
  input  logic                    clr_we,
  input  logic [2*NCAP-1:0]       clr_mask,
  output logic [IVL_W-1:0]        ivl_count,
  output logic                    ivl_irq,
  output logic                    tio_out,
  output logic [FRC_W-1:0]        frc_count,
  output logic                    wrap_irq,
  output logic [2*NCAP-1:0]       cap_status,
  output logic [2*NCAP*FRC_W-1:0] cap_data
);
  localparam int NEV = 2 * NCAP;

  logic           presc_tick;
  logic [NEV-1:0] cap_evt;
  logic [NEV-1:0] clr_hit;

  assign clr_hit = clr_we ? clr_mask : '0;

  ict_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .src_sel(src_sel), .ratio_sel(ratio_sel), .tick(presc_tick)
  );

  ict_interval #(.W(IVL_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .tick(presc_tick), .reload(reload_val),
    .count(ivl_count), .pulse(ivl_irq)
  );

  assign tio_out = ivl_irq & tio_en;

  ict_frc #(.W(FRC_W)) u_frc (
    .clk(clk), .rst_n(rst_n), .tick(presc_tick),
    .count(frc_count), .wrap(wrap_irq)
  );

  for (genvar c = 0; c < NCAP; c++) begin : g_ch
    ict_capture_ch #(.W(FRC_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[c]), .hold(first_hold),
      .stamp(frc_count), .clr(clr_hit[2*c +: 2]),
      .evt(cap_evt[2*c +: 2]), .held(cap_status[2*c +: 2]),
      .data(cap_data[2*c*FRC_W +: 2*FRC_W])
    );
  end
endmodule

module ivl_cap_timer_chk #(
  parameter int IVL_W = 12,
  parameter int FRC_W = 16,
  parameter int NEV   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 presc_tick,
  input logic [IVL_W-1:0]     reload_val,
  input logic [IVL_W-1:0]     ivl_count,
  input logic                 ivl_irq,
  input logic [FRC_W-1:0]     frc_count,
  input logic                 wrap_irq,
  input logic                 first_hold,
  input logic                 clr_we,
  input logic [NEV-1:0]       clr_mask,
  input logic [NEV-1:0]       cap_evt,
  input logic [NEV-1:0]       cap_status,
  input logic [NEV*FRC_W-1:0] cap_data
);
  // R2
  count_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl_count != $past(ivl_count)) |-> $past(presc_tick));

  // R3
  reload_loads_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_irq |-> (ivl_count == $past(reload_val)));

  // R3
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_irq |=> !ivl_irq);

  // R6
  wrap_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |-> (frc_count == '0));

  for (genvar k = 0; k < NEV; k++) begin : g_ev
    // R10
    status_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cap_status[k]) |-> $past(clr_we && clr_mask[k]));

    // R9
    hold_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(first_hold && cap_status[k] && !(clr_we && clr_mask[k]))
        |-> (cap_data[k*FRC_W +: FRC_W] == $past(cap_data[k*FRC_W +: FRC_W])));

    // R12
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[k] |=> !cap_evt[k]);
  end
endmodule

bind ivl_cap_timer ivl_cap_timer_chk #(.IVL_W(IVL_W), .FRC_W(FRC_W), .NEV(2*NCAP)) chk_i (
  .clk(clk), .rst_n(rst_n), .presc_tick(presc_tick), .reload_val(reload_val),
  .ivl_count(ivl_count), .ivl_irq(ivl_irq), .frc_count(frc_count),
  .wrap_irq(wrap_irq), .first_hold(first_hold), .clr_we(clr_we),
  .clr_mask(clr_mask), .cap_evt(cap_evt), .cap_status(cap_status),
  .cap_data(cap_data)
);

// File: tb/ivl_cap_timer_tb_top.sv
`timescale 1ns/1ps
module ivl_cap_timer_tb_top;
  localparam int IVL_W = 12;
  localparam int FRC_W = 16;
  localparam int NCAP  = 2;
  localparam int NEV   = 2 * NCAP;

  logic clk, rst_n, src_a, src_b, src_sel, tio_en, first_hold, clr_we;
  logic [1:0]             ratio_sel;
  logic [IVL_W-1:0]       reload_val;
  logic [NCAP-1:0]        cap_in;
  logic [NEV-1:0]         clr_mask;
  logic [IVL_W-1:0]       ivl_count;
  logic                   ivl_irq, tio_out, wrap_irq;
  logic [FRC_W-1:0]       frc_count;
  logic [NEV-1:0]         cap_status;
  logic [NEV*FRC_W-1:0]   cap_data;

  ivl_cap_timer dut_i (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .src_sel(src_sel),
    .ratio_sel(ratio_sel), .reload_val(reload_val), .tio_en(tio_en),
    .first_hold(first_hold), .cap_in(cap_in), .clr_we(clr_we), .clr_mask(clr_mask),
    .ivl_count(ivl_count), .ivl_irq(ivl_irq), .tio_out(tio_out),
    .frc_count(frc_count), .wrap_irq(wrap_irq), .cap_status(cap_status),
    .cap_data(cap_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, pulses_seen = 0, wraps_seen = 0;
  bit chk_on = 0, done = 0;

  // behavioural reference state
  int  m_pcnt = 0, m_ivl = 0, m_frc = 0, m_old_frc = 0;
  bit  m_pulse = 0, m_wrap = 0, m_tick = 0;
  int  m_cap[NEV];
  bit  m_st[NEV];
  int  hist[$];
  int  m_src, m_cur, m_prv;
  bit  m_a, m_b, m_ev, m_clr;

  initial begin
    for (int k = 0; k < NEV; k++) begin m_cap[k] = 0; m_st[k] = 0; end
    hist = '{0, 0, 0};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pcnt = 0; m_ivl = 0; m_frc = 0; m_pulse = 0; m_wrap = 0;
      for (int k = 0; k < NEV; k++) begin m_cap[k] = 0; m_st[k] = 0; end
      hist = '{0, 0, 0};
    end else begin
      m_src  = src_sel ? int'(src_b) : int'(src_a);
      m_tick = (m_src != 0) && (m_pcnt >= 2 * int'(ratio_sel) + 1);
      if (m_src != 0) m_pcnt = m_tick ? 0 : m_pcnt + 1;
      m_pulse = 0;
      if (m_tick) begin
        if (m_ivl == 0) begin m_ivl = int'(reload_val); m_pulse = 1; end
        else m_ivl = m_ivl - 1;
      end
      m_old_frc = m_frc;
      m_wrap = m_tick && (m_frc == 65535);
      if (m_tick) m_frc = (m_frc + 1) % 65536;
      m_cur = hist[1];
      m_prv = hist[2];
      for (int k = 0; k < NEV; k++) begin
        m_a   = ((m_cur >> (k / 2)) & 1) != 0;
        m_b   = ((m_prv >> (k / 2)) & 1) != 0;
        m_ev  = (k % 2 == 0) ? (m_a && !m_b) : (!m_a && m_b);
        m_clr = clr_we && clr_mask[k];
        if (m_ev) begin
          if (!first_hold || !m_st[k] || m_clr) m_cap[k] = m_old_frc;
          m_st[k] = 1;
        end else if (m_clr) m_st[k] = 0;
      end
      hist.push_front(int'(cap_in));
      void'(hist.pop_back());
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      cmp("R2 R3 R4 interval count", int'(ivl_count), m_ivl);
      cmp("R3 interval pulse", int'(ivl_irq), int'(m_pulse));
      cmp("R5 timer pin", int'(tio_out), int'(m_pulse && tio_en));
      cmp("R6 free-running count", int'(frc_count), m_frc);
      cmp("R6 wrap pulse", int'(wrap_irq), int'(m_wrap));
      for (int k = 0; k < NEV; k++) begin
        cmp("R7 R8 R9 R11 R12 capture data", int'(cap_data[k*FRC_W +: FRC_W]), m_cap[k]);
        cmp("R10 R11 capture status", int'(cap_status[k]), int'(m_st[k]));
      end
      if (ivl_irq) pulses_seen++;
      if (wrap_irq) wraps_seen++;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(5.0 * 195000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 0; src_a = 0; src_b = 0; src_sel = 0; ratio_sel = 0; reload_val = 0;
    tio_en = 0; first_hold = 0; cap_in = 0; clr_we = 0; clr_mask = 0;
    repeat (4) step();
    // R1: reset values
    cmp("R1 reset interval count", int'(ivl_count), 0);
    cmp("R1 reset pulse", int'(ivl_irq), 0);
    cmp("R1 reset pin", int'(tio_out), 0);
    cmp("R1 reset free count", int'(frc_count), 0);
    cmp("R1 reset wrap", int'(wrap_irq), 0);
    cmp("R1 reset status", int'(cap_status), 0);
    cmp("R1 reset data", (cap_data == '0) ? 1 : 0, 1);
    rst_n = 1; chk_on = 1;

    // R3: steady reload, strobe always on, ratio 2
    src_a = 1; reload_val = 5; tio_en = 1;
    repeat (60) step();
    cmp("R3 pulses observed", (pulses_seen > 0) ? 1 : 0, 1);

    // R4: reload changes mid-count
    reload_val = 9; repeat (7) step();
    reload_val = 3; repeat (5) step();
    reload_val = 0; repeat (20) step();
    reload_val = 4; repeat (40) step();

    // R5: pin gating
    tio_en = 0; repeat (40) step();
    tio_en = 1; repeat (20) step();

    // R2: other strobe with gaps, every ratio, plus a mid-count ratio change
    src_sel = 1;
    for (int r = 0; r < 4; r++) begin
      ratio_sel = 2'(r);
      for (int i = 0; i < 70; i++) begin src_b = (i % 3 != 1); step(); end
    end
    ratio_sel = 0; repeat (3) step();
    src_sel = 0; src_a = 1; src_b = 0; ratio_sel = 0;

    // R7 R8 R12: latest-edge captures on both pins
    first_hold = 0;
    for (int i = 0; i < 8; i++) begin
      cap_in[0] = ~cap_in[0]; repeat (7) step();
      if (i % 2 == 0) cap_in[1] = ~cap_in[1];
      repeat (5) step();
    end
    repeat (30) step();

    // R9: first-edge hold, then R10 masked clears
    first_hold = 1;
    for (int i = 0; i < 6; i++) begin
      cap_in = ~cap_in; repeat (9) step();
    end
    clr_we = 1; clr_mask = 4'b0101; step();
    clr_we = 0; clr_mask = 0; repeat (4) step();
    for (int i = 0; i < 4; i++) begin cap_in = ~cap_in; repeat (9) step(); end
    clr_we = 1; clr_mask = 4'b1010; step();
    clr_we = 0; clr_mask = 0; repeat (4) step();

    // R11: sweep a full clear across the cycle an event lands
    for (int off = 0; off < 5; off++) begin
      cap_in[0] = ~cap_in[0];
      repeat (off) step();
      clr_we = 1; clr_mask = 4'b1111; step();
      clr_we = 0; clr_mask = 0; repeat (8) step();
    end

    // R6: run through a rollover
    first_hold = 0;
    for (int i = 0; i < 132000 && wraps_seen == 0; i++) step();
    repeat (5) step();
    cmp("R6 rollover observed", (wraps_seen > 0) ? 1 : 0, 1);

    chk_on = 0; done = 1;
    report();
    $finish;
  end
endmodule